// File: doc/BRIEF.md
# Programmable Binary Divider Timer

A synchronous timer that counts rising edges of a slow timing input and drives one output bit from a selectable stage of its binary counter. The timing input is never used as a clock. It passes through a two-flop synchronizer and an edge detector on the system clock, and each detected rising edge advances the counter by exactly one. A 2-bit select picks one of four counter stages. With the default parameters these give divide ratios of 2^13, 2^8, 2^10 and 2^16.

The output works in one of two modes. In divider mode it toggles continuously, with a period of 2^n timing edges. In single-transition mode it flips once, after 2^(n-1) edges, and then stays latched. A phase input sets the output level that holds after any reset. A synchronous master reset clears the counter and the latch. An optional power-on reset can also hold the counter clear: when its active-low enable is asserted, it does so for a fixed number of system clocks after the asynchronous reset is released.

Top module: `prog_div_timer`

## Requirements
- R1: Each rising edge of `tmr_i` advances the counter by exactly one. The edge is reflected at `out_o` within three system clocks. Level and falling edges do not count.
- R2: The tap select maps as follows, where `sel_i[0]` is the first address bit and `sel_i[1]` the second: value 0 gives stage n=N_SEL0 (13), value 1 gives N_SEL1 (8), value 2 gives N_SEL2 (10), and value 3 gives N_SEL3 (16).
- R3: With `mode_i`=1, `out_o` equals counter bit n-1 XOR `phase_i`. The output period is therefore 2^n timing edges.
- R4: With `mode_i`=0, `out_o` equals `phase_i` until the 2^(n-1)-th edge after a clear. It then equals the complement of `phase_i` and holds that value, even when the counter wraps.
- R5: While `mr_i`=1, the counter and latch are cleared and timing edges are ignored. One clock after `mr_i` is seen high, `out_o` equals `phase_i`.
- R6: A low-to-high change of `mode_i` clears the single-transition latch. On returning to `mode_i`=0, the output again follows the count from its current value.
- R7: After a clear, `out_o` starts low when `phase_i`=0 and starts high when `phase_i`=1, and the whole waveform is inverted.
- R8: With `por_en_ni`=0, the counter is held clear for POR_CYCLES (16) system clocks after `rst_ni` rises, and edges during that window are ignored. With `por_en_ni`=1, counting starts at once.
- R9: A change of `sel_i` reaches `out_o` one clock later. It does not clear the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmr_i | input | 1 | Asynchronous timing input; rising edges count |
| mr_i | input | 1 | Synchronous master reset, active high |
| por_en_ni | input | 1 | Power-on reset enable, active low |
| sel_i | input | 2 | Counter tap select |
| mode_i | input | 1 | 1 = continuous divider, 0 = single transition |
| phase_i | input | 1 | Output polarity after clear |
| out_o | output | 1 | Timer output |

## Verification
A counter that drops or duplicates an edge shows up as a misplaced output transition. The offset is visible at the first selected-stage boundary after the fault, which is at most 2^(n-1) edges later, so the small-stage selects expose it within a few edges. A latch that sets too early, fails to hold, or survives a mode rise or master reset changes `out_o` in the very cycle after the offending event. A power-on window of the wrong length leaves an early edge counted or lost, and this is visible as soon as the small stage crosses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NUM_TAPS = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_TAPS);
  typedef logic [SEL_W-1:0] tap_sel_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R1: one pulse per edge
  a_r1_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_por.sv
module tmr_por #(
  parameter int unsigned POR_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_en_ni,
  output logic por_active_o
);
  localparam int unsigned PW = $clog2(POR_CYCLES + 1);
  localparam logic [PW-1:0] LIMIT = PW'(POR_CYCLES);

  logic [PW-1:0] cnt_q;
  logic          done;

  assign done = (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (!done) cnt_q <= cnt_q + 1'b1;
  end

  assign por_active_o = ~por_en_ni & ~done;

  // R8: once the window closes it never reopens
  a_r8_window_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !por_active_o);
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_SEL0 = 13,
  parameter int unsigned N_SEL1 = 8,
  parameter int unsigned N_SEL2 = 10,
  parameter int unsigned N_SEL3 = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     tick_i,
  input  tap_sel_t sel_i,
  output logic     tap_o
);
  localparam int unsigned TAP_N [NUM_TAPS] = '{N_SEL0, N_SEL1, N_SEL2, N_SEL3};

  logic [CNT_W-1:0]    cnt_q;
  logic [NUM_TAPS-1:0] taps;
  tap_sel_t            sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // select is registered; counter untouched by a change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_i;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign taps[g] = cnt_q[TAP_N[g]-1];
  end

  assign tap_o = taps[sel_q];

  a_r1_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tick_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(cnt_q));
  a_r9_sel_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i && sel_i != sel_q) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_out.sv
module tmr_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tap_i,
  input  logic mode_i,
  input  logic phase_i,
  output logic out_o
);
  logic mode_q;
  logic hold_q;
  logic mode_rise;

  assign mode_rise = mode_i & ~mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (clr_i || mode_rise)    hold_q <= 1'b0;
      else if (!mode_i && tap_i) hold_q <= 1'b1;
    end
  end

  assign out_o = phase_i ^ (mode_i ? tap_i : (hold_q | tap_i));

  // R4: latch holds in single mode until cleared
  a_r4_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !mode_i && !clr_i) |=> hold_q);
  // R6: mode rise clears latch
  a_r6_rise_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_rise |=> !hold_q);
endmodule

// File: rtl/prog_div_timer.sv
module prog_div_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned N_SEL0     = 13,
  parameter int unsigned N_SEL1     = 8,
  parameter int unsigned N_SEL2     = 10,
  parameter int unsigned N_SEL3     = 16,
  parameter int unsigned POR_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tmr_i,
  input  logic       mr_i,
  input  logic       por_en_ni,
  input  logic [1:0] sel_i,
  input  logic       mode_i,
  input  logic       phase_i,
  output logic       out_o
);
  logic tick;
  logic por_active;
  logic clr;
  logic tap;

  assign clr = mr_i | por_active;

  tmr_edge_sync #(.SYNC_STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (tmr_i),
    .rise_o  (tick)
  );

  tmr_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .por_en_ni    (por_en_ni),
    .por_active_o (por_active)
  );

  tmr_count #(
    .CNT_W (CNT_W), .N_SEL0(N_SEL0), .N_SEL1(N_SEL1),
    .N_SEL2(N_SEL2), .N_SEL3(N_SEL3)
  ) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_i (tick),
    .sel_i  (tap_sel_t'(sel_i)),
    .tap_o  (tap)
  );

  tmr_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tap_i   (tap),
    .mode_i  (mode_i),
    .phase_i (phase_i),
    .out_o   (out_o)
  );

  // R5: a cycle of master reset returns output to phase level
  a_r5_mr_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mr_i) |-> out_o == phase_i);
endmodule

// File: tb/tb_prog_div_timer.sv
module tb_prog_div_timer;
  localparam int CNT_W = 6;
  localparam int NS0 = 4, NS1 = 2, NS2 = 3, NS3 = 6;

  logic clk = 0, rst_ni = 0, tmr = 0, mr = 0, por_en_n = 1;
  logic [1:0] sel = 0;
  logic mode = 1, phase = 0;
  logic out;
  int n_chk = 0, n_bad = 0;
  int k = 0;
  bit flag = 0;

  always #2 clk = ~clk;

  prog_div_timer #(.CNT_W(CNT_W), .N_SEL0(NS0), .N_SEL1(NS1), .N_SEL2(NS2),
                   .N_SEL3(NS3), .POR_CYCLES(16)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tmr_i(tmr), .mr_i(mr), .por_en_ni(por_en_n),
    .sel_i(sel), .mode_i(mode), .phase_i(phase), .out_o(out));

  function automatic int nsel(input logic [1:0] s);
    case (s) 2'd0: return NS0; 2'd1: return NS1; 2'd2: return NS2; default: return NS3; endcase
  endfunction

  function automatic logic tapv();
    return logic'((k % (1 << CNT_W)) >> (nsel(sel) - 1));
  endfunction

  function automatic logic exp_out();
    if (mode) return phase ^ tapv();
    return phase ^ (flag | tapv());
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: out=%0b expected=%0b (k=%0d sel=%0d mode=%0b)", req, act, exp, k, sel, mode);
    end
  endtask

  task automatic edge_pulse(input bit counts);
    @(negedge clk) tmr = 1;
    repeat (3) @(negedge clk);
    tmr = 0;
    repeat (3) @(negedge clk);
    if (counts) begin
      k++;
      if (!mode && tapv()) flag = 1;
    end
  endtask

  task automatic master_clear();
    @(negedge clk) mr = 1;
    @(negedge clk) chk("R5", out, phase);
    mr = 0;
    k = 0; flag = 0;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic pen);
    @(negedge clk) rst_ni = 0; por_en_n = pen;
    k = 0; flag = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin
    repeat (3000000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R7 reset phase0", out, 1'b0);
    phase = 1; #0;
    @(negedge clk) chk("R7 reset phase1", out, 1'b1);

    // R3 R2 R7 divider sweep
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 4; s++) begin
        phase = p[0]; sel = s[1:0]; mode = 1;
        master_clear();
        for (int e = 0; e < 2 * (1 << nsel(sel)); e++) begin
          edge_pulse(1);
          chk("R3/R2 divider", out, exp_out());
        end
      end
    end

    // R4 single-transition sweep, past counter wrap
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 4; s++) begin
        phase = p[0]; sel = s[1:0]; mode = 0;
        master_clear();
        for (int e = 0; e < 80; e++) begin
          edge_pulse(1);
          chk("R4 single", out, phase ^ (k >= (1 << (nsel(sel) - 1))));
        end
      end
    end

    // R1 level/fall does not count: long high
    phase = 0; sel = 1; mode = 1;
    master_clear();
    @(negedge clk) tmr = 1;
    repeat (20) @(negedge clk);
    k = 1;
    chk("R1 one edge per rise", out, exp_out());
    tmr = 0;
    repeat (20) @(negedge clk);
    chk("R1 fall ignored", out, exp_out());
    edge_pulse(1);
    chk("R1 second rise", out, exp_out());

    // R5 edges ignored during master reset
    sel = 1; mode = 1; phase = 0;
    @(negedge clk) mr = 1;
    edge_pulse(0); edge_pulse(0);
    mr = 0; k = 0; flag = 0;
    @(negedge clk) chk("R5 held", out, 1'b0);
    edge_pulse(1); chk("R5 k1", out, exp_out());
    edge_pulse(1); chk("R5 k2", out, 1'b1);

    // R6 mode rise clears latch
    sel = 1; mode = 0; phase = 1;
    master_clear();
    repeat (4) edge_pulse(1);
    chk("R6 latched", out, 1'b0);
    @(negedge clk) mode = 1;
    @(negedge clk) mode = 0;
    flag = 0;
    @(negedge clk) chk("R6 cleared", out, 1'b1);
    edge_pulse(1); chk("R6 k5", out, 1'b1);
    edge_pulse(1); chk("R6 k6", out, 1'b0);

    // R9 select change keeps count
    sel = 0; mode = 1; phase = 0;
    master_clear();
    repeat (4) edge_pulse(1);
    chk("R9 before", out, 1'b0);
    @(negedge clk) sel = 2;
    @(negedge clk) chk("R9 after", out, 1'b1);
    @(negedge clk) sel = 1;
    @(negedge clk) chk("R9 after2", out, 1'b0);

    // R8 power-on window enabled
    sel = 1; mode = 1; phase = 0;
    do_reset(1'b0);
    edge_pulse(0); edge_pulse(0);
    repeat (10) @(negedge clk);
    chk("R8 por ignored", out, 1'b0);
    edge_pulse(1); chk("R8 k1", out, 1'b0);
    edge_pulse(1); chk("R8 k2", out, 1'b1);

    // R8 power-on disabled
    do_reset(1'b1);
    edge_pulse(1); edge_pulse(1);
    repeat (10) @(negedge clk);
    chk("R8 no por", out, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule